// File: doc/BRIEF.md
# Synchronous Serial Sample Transmitter

This block streams receiver sample packets to a signal processor over a synchronous serial link. The block is the clock master on that link. It divides its system clock down to a serial bit clock and drives that clock out. Once per frame it raises a frame-sync pulse, which the processor uses both as a word-alignment marker and as its packet-arrival interrupt. It shifts the packet bits out on a single data line. The nominal numbers are a 19.2 MHz system clock, a 2.4 MHz bit clock (divide by 8) and a 20 kHz frame rate, so one frame spans 120 bit periods and matches the receive sampling rate.

Each packet carries two sample words. In raw mode these are the in-phase and quadrature IF samples. In baseband mode the first slot carries the demodulated word and the second slot carries zeros. Sample pairs arrive as parallel words with a one-cycle strobe. A pair is held until the next frame boundary and is never inserted into a frame that has already started. If a frame begins with no fresh pair waiting, the previous pair is sent again and a sticky underrun flag is raised.

Top module: `sample_link_tx`

## Requirements
- R1: `sckt` is a square wave with a period of CLK_DIV system clocks, high for CLK_DIV/2 of them. Each bit period begins with a rising edge of `sckt`.
- R2: Every frame lasts exactly FRAME_BITS bit periods, and `tfs` rises once per frame.
- R3: `tfs` is high for exactly one bit period, namely the period that carries the first (most significant) bit of the first word.
- R4: `txd` and `tfs` change only on the system clock edge at which `sckt` rises, so the receiver can sample them on the falling edge.
- R5: In raw mode (`mode_bb` = 0) the frame carries `smp_i` in bit periods 0 to WORD_W-1, then `smp_q` in bit periods WORD_W to 2*WORD_W-1, each most significant bit first.
- R6: `txd` is low in every bit period from 2*WORD_W to FRAME_BITS-1.
- R7: In baseband mode (`mode_bb` = 1) the first word slot carries `smp_bb` and the second slot carries all zeros, whatever `smp_i` and `smp_q` hold. The mode is taken from the cycle in which `smp_valid` is high.
- R8: A pair strobed while a frame is in progress is sent in the next frame. When several pairs arrive within one frame, only the most recent one is sent.
- R9: If no pair has arrived since the previous frame boundary, the last sent pair is sent again and `underrun` goes high. It then stays high until reset. The stored pair resets to all zeros.
- R10: While reset is asserted, `sckt`, `tfs`, `txd` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_bb | input | 1 | 0 = raw I/Q pair, 1 = demodulated baseband word; sampled with `smp_valid` |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair on the word inputs |
| smp_i | input | WORD_W | In-phase IF sample |
| smp_q | input | WORD_W | Quadrature IF sample |
| smp_bb | input | WORD_W | Demodulated baseband word |
| sckt | output | 1 | Serial bit clock driven to the processor |
| tfs | output | 1 | Frame-sync pulse and packet interrupt, one bit period wide |
| txd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Sticky flag: a frame resent a stale pair |

## Verification
The bench builds the block with CLK_DIV = 4, FRAME_BITS = 40 and WORD_W = 8, so a frame lasts 160 system clocks instead of 960. At that length, several full frames with 24 padding bits each complete within a short run. That makes room to cover a pair latched across reset release, a baseband packet with non-zero I/Q inputs that must not leak, two strobes in one frame, a frame with no strobe, and the sticky flag surviving later fresh data. Frame length, sync width and edge alignment are measured on every frame.

// File: rtl/sltx_pkg.sv
package sltx_pkg;
  typedef enum logic {
    MODE_RAW = 1'b0,
    MODE_BB  = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/sltx_bitclk.sv
module sltx_bitclk #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic sckt,
  output logic bit_tick
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_FALL = CNT_W'(CLK_DIV / 2 - 1);

  logic [CNT_W-1:0] div_q, div_d;
  logic             sckt_q, sckt_d;

  assign bit_tick = (div_q == CNT_LAST);
  assign sckt     = sckt_q;

  always_comb begin
    div_d  = bit_tick ? '0 : div_q + 1'b1;
    sckt_d = sckt_q;
    if (bit_tick)
      sckt_d = 1'b1;
    else if (div_q == CNT_FALL)
      sckt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sckt_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sckt_q <= sckt_d;
    end
  end

  a_r1_rise_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sckt_q) |-> (div_q == '0));
endmodule

// File: rtl/sltx_framer.sv
module sltx_framer #(
  parameter int FRAME_BITS = 120
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_tick,
  output logic                          frame_start,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  output logic                          tfs
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             tfs_q, tfs_d;

  assign frame_start = bit_tick && (idx_q == IDX_LAST);
  assign bit_idx     = idx_q;
  assign tfs         = tfs_q;

  always_comb begin
    idx_d = idx_q;
    tfs_d = tfs_q;
    if (bit_tick) begin
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      tfs_d = (idx_q == IDX_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_LAST;
      tfs_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      tfs_q <= tfs_d;
    end
  end

  a_r3_sync_only_on_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tfs_q |-> (idx_q == '0));
endmodule

// File: rtl/sltx_holder.sv
module sltx_holder
  import sltx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic                  mode_bb,
  input  logic [WORD_W-1:0]     smp_i,
  input  logic [WORD_W-1:0]     smp_q,
  input  logic [WORD_W-1:0]     smp_bb,
  input  logic                  frame_start,
  output logic [2*WORD_W-1:0]   load_word,
  output logic                  underrun
);
  localparam int PAIR_W = 2 * WORD_W;

  tx_mode_e          mode;
  logic [PAIR_W-1:0] cap_word;
  logic [PAIR_W-1:0] pend_q, pend_d;
  logic              full_q, full_d;
  logic [PAIR_W-1:0] last_q, last_d;
  logic              ur_q, ur_d;

  assign mode      = tx_mode_e'(mode_bb);
  assign load_word = full_q ? pend_q : last_q;
  assign underrun  = ur_q;

  always_comb begin
    if (mode == MODE_BB)
      cap_word = {smp_bb, {WORD_W{1'b0}}};
    else
      cap_word = {smp_i, smp_q};
  end

  always_comb begin
    pend_d = pend_q;
    full_d = full_q;
    last_d = last_q;
    ur_d   = ur_q;
    if (frame_start) begin
      last_d = load_word;
      if (!full_q)
        ur_d = 1'b1;
      full_d = smp_valid;
    end
    if (smp_valid) begin
      pend_d = cap_word;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      full_q <= 1'b0;
      last_q <= '0;
      ur_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      full_q <= full_d;
      last_q <= last_d;
      ur_q   <= ur_d;
    end
  end

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ur_q |=> ur_q);
  a_r9_underrun_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ur_q) |-> $past(frame_start));
endmodule

// File: rtl/sltx_shifter.sv
module sltx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                frame_start,
  input  logic [2*WORD_W-1:0] load_word,
  output logic                txd
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;

  assign txd = txd_q;

  always_comb begin
    sh_d  = sh_q;
    txd_d = txd_q;
    if (bit_tick) begin
      if (frame_start) begin
        txd_d = load_word[PAIR_W-1];
        sh_d  = {load_word[PAIR_W-2:0], 1'b0};
      end else begin
        txd_d = sh_q[PAIR_W-1];
        sh_d  = {sh_q[PAIR_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      txd_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      txd_q <= txd_d;
    end
  end
endmodule

// File: rtl/sample_link_tx.sv
module sample_link_tx #(
  parameter int CLK_DIV    = 8,
  parameter int FRAME_BITS = 120,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_bb,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_i,
  input  logic [WORD_W-1:0] smp_q,
  input  logic [WORD_W-1:0] smp_bb,
  output logic              sckt,
  output logic              tfs,
  output logic              txd,
  output logic              underrun
);
  localparam int IDX_W     = $clog2(FRAME_BITS);
  localparam int PAD_START = 2 * WORD_W;

  logic                rst_meta_q, rst_sync_q;
  logic                bit_tick;
  logic                frame_start;
  logic [IDX_W-1:0]    bit_idx;
  logic [2*WORD_W-1:0] load_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sltx_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sckt     (sckt),
    .bit_tick (bit_tick)
  );

  sltx_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bit_tick    (bit_tick),
    .frame_start (frame_start),
    .bit_idx     (bit_idx),
    .tfs         (tfs)
  );

  sltx_holder #(.WORD_W(WORD_W)) u_holder (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .smp_valid   (smp_valid),
    .mode_bb     (mode_bb),
    .smp_i       (smp_i),
    .smp_q       (smp_q),
    .smp_bb      (smp_bb),
    .frame_start (frame_start),
    .load_word   (load_word),
    .underrun    (underrun)
  );

  sltx_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bit_tick    (bit_tick),
    .frame_start (frame_start),
    .load_word   (load_word),
    .txd         (txd)
  );

  a_r4_txd_moves_with_rise: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (txd != $past(txd)) |-> $rose(sckt));
  a_r3_tfs_rises_with_sckt: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(tfs) |-> $rose(sckt));
  a_r3_tfs_falls_with_sckt: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(tfs) |-> $rose(sckt));
  a_r6_padding_low: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (32'(bit_idx) >= PAD_START) |-> !txd);
endmodule

// File: tb/sample_link_tx_tb_top.sv
module sample_link_tx_tb_top;
  localparam int DIV = 4;
  localparam int F   = 40;
  localparam int W   = 8;
  localparam int PW  = 2 * W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_bb;
  logic         smp_valid;
  logic [W-1:0] smp_i, smp_q, smp_bb;
  logic         sckt, tfs, txd, underrun;

  always #2.5 clk = ~clk;

  sample_link_tx #(.CLK_DIV(DIV), .FRAME_BITS(F), .WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_bb(mode_bb), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .smp_bb(smp_bb),
    .sckt(sckt), .tfs(tfs), .txd(txd), .underrun(underrun)
  );

  typedef struct {
    logic [PW-1:0] word;
    logic          ur;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   frame_cnt = 0;
  int   frames_done = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // driver: applies one strobe and pushes the packet expected in the next frame
  task automatic send(input logic md, input logic [W-1:0] i, input logic [W-1:0] q,
                      input logic [W-1:0] bb, input int hold, input bit push,
                      input logic ur, input string tag);
    exp_t e;
    @(negedge clk);
    mode_bb = md; smp_i = i; smp_q = q; smp_bb = bb; smp_valid = 1'b1;
    repeat (hold) @(negedge clk);
    smp_valid = 1'b0;
    smp_i = '1; smp_q = '1; smp_bb = '1; mode_bb = ~md;
    if (push) begin
      e.word = md ? {bb, {W{1'b0}}} : {i, q};
      e.ur   = ur;
      e.tag  = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic expect_stale(input logic [PW-1:0] w, input string tag);
    exp_t e;
    e.word = w; e.ur = 1'b1; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: watches the serial port at the falling system clock edge
  initial begin : monitor
    logic          prev_sckt, prev_txd, prev_tfs, rise;
    logic [F-1:0]  rx;
    int            since_rise, nbits;
    bit            have_rise, in_frame;
    exp_t          e;
    prev_sckt = 1'b0; prev_txd = 1'b0; prev_tfs = 1'b0;
    rx = '0; since_rise = 0; nbits = 0; have_rise = 0; in_frame = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        rise = sckt && !prev_sckt;
        since_rise++;
        if ((txd !== prev_txd) || (tfs !== prev_tfs))
          chk("R4 txd/tfs change only at sckt rise", rise, 1'b1);
        if (rise) begin
          if (have_rise)
            chk("R1 sckt period", since_rise, DIV);
          since_rise = 0;
          have_rise  = 1;
          if (tfs) begin
            if (in_frame)
              chk("R2 frame length", nbits, F);
            nbits = 0;
            in_frame = 1;
            frame_cnt++;
          end else if (in_frame && nbits == 1) begin
            chk("R3 tfs low on second bit", tfs, 1'b0);
          end
          if (in_frame) begin
            rx = {rx[F-2:0], txd};
            nbits++;
            if (nbits == F) begin
              if (exp_q.size() == 0) begin
                chk("R8 unexpected frame", 1, 0);
              end else begin
                e = exp_q.pop_front();
                chk({e.tag, " word slots"}, 64'(rx[F-1 -: PW]), 64'(e.word));
                chk("R6 padding low", 64'(|rx[F-PW-1:0]), 0);
                chk("R9 underrun flag", underrun, e.ur);
              end
              frames_done++;
            end
          end
        end
        if (sckt && !prev_sckt == 1'b0 && prev_sckt == 1'b0) begin
        end
      end
      prev_sckt = sckt; prev_txd = txd; prev_tfs = tfs;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin : stimulus
    rst_n = 1'b0; smp_valid = 1'b0; mode_bb = 1'b0;
    smp_i = '0; smp_q = '0; smp_bb = '0;
    repeat (6) @(negedge clk);
    chk("R10 sckt in reset", sckt, 0);
    chk("R10 tfs in reset", tfs, 0);
    chk("R10 txd in reset", txd, 0);
    chk("R10 underrun in reset", underrun, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // pair presented across reset release, expected in the first frame (R5)
    mode_bb = 1'b0; smp_i = 8'hA5; smp_q = 8'h3C; smp_valid = 1'b1;
    begin
      exp_t e;
      e.word = {8'hA5, 8'h3C}; e.ur = 1'b0; e.tag = "R5 first raw pair";
      exp_q.push_back(e);
    end
    repeat (4) @(negedge clk);
    smp_valid = 1'b0;

    wait (frame_cnt == 1);
    repeat (20) @(negedge clk);
    send(1'b0, 8'h81, 8'h7E, 8'h00, 1, 1, 1'b0, "R8 mid-frame pair to next frame");

    wait (frame_cnt == 2);
    repeat (30) @(negedge clk);
    send(1'b1, 8'hFF, 8'hC3, 8'h5A, 1, 1, 1'b0, "R7 baseband slot, Q zero");

    wait (frame_cnt == 3);
    repeat (10) @(negedge clk);
    send(1'b0, 8'h11, 8'h22, 8'h00, 1, 0, 1'b0, "");
    repeat (40) @(negedge clk);
    send(1'b0, 8'hE4, 8'h1B, 8'h00, 1, 1, 1'b0, "R8 newest pair wins");

    wait (frame_cnt == 4);
    expect_stale({8'hE4, 8'h1B}, "R9 stale resend");

    wait (frame_cnt == 5);
    repeat (25) @(negedge clk);
    send(1'b0, 8'h96, 8'h69, 8'h00, 1, 1, 1'b1, "R9 sticky after fresh pair");

    wait (frames_done == 6);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule